// File: doc/BRIEF.md
# Stepper Microstep Phase Sequencer

This block turns a step strobe and a direction bit into signed current setpoints for the two windings of a bipolar stepping motor. It keeps a position of 64 slots around one electrical cycle. A two-bit resolution code sets how many slots each step skips. A fixed quarter-wave table then turns the position into a cosine setpoint for winding A and a sine setpoint for winding B. Each setpoint is a magnitude in percent of full scale plus a negative flag, and a two-bit torque code scales the magnitude down.

An active-low home input puts the sequencer back at its starting angle of 45 degrees. The home input is also the only moment at which a new resolution code is taken in. An enable input gates the setpoint outputs, and the position keeps counting while the outputs are gated. A monitor output goes low while the sequencer stands at the home position. Everything runs on one system clock. The step strobe is sampled on that clock, and each of its rising edges moves the sequencer by one step.

Top module: `stepper_phase_seq`

## Requirements
- R1: Resolution code `mode_i` selects the number of positions per electrical cycle: 00 = 4 (full step), 01 = 8 (half step), 11 = 32 (8-level), 10 = 64 (16-level). Stepping past the last position wraps, so a full cycle of steps returns to the starting setpoint.
- R2: The magnitude of the quarter wave follows the sequence 0,10,20,29,38,47,56,63,71,77,83,88,92,96,98,100,100 over fine slots 0..16. The 8-level mode uses every second entry, and half step uses entries 0, 8 and 16. In full step both magnitudes are always 100.
- R3: The home position is 45 degrees, where both setpoints are +71 (+100 in full step). `at_home_n_o` is low exactly when the position is home.
- R4: With `dir_i` = 1 the angle increases: winding A falls and winding B rises. For example, one half step from home gives A = 0 and B = +100. With `dir_i` = 0 the angle decreases, so one half step gives A = +100 and B = 0. Winding A is negative in the second and third quadrants, and winding B is negative in the third and fourth.
- R5: While `en_i` is low, both magnitudes, both negative flags and `drive_en_o` are 0. Step strobes still move the position, and the moved position shows once `en_i` returns high.
- R6: While `home_n_i` is low, the position is held at home and step strobes are ignored.
- R7: `mode_i` is captured only while `home_n_i` is low. Changes at any other time have no effect.
- R8: The torque code `torque_i` scales magnitudes to 100% (00), 75% (01), 50% (10) or 20% (11), computed as floor(table x percent / 100). No magnitude exceeds 100.
- R9: A negative flag is set only with a nonzero magnitude.
- R10: Each rising edge of `step_i` moves the position exactly once, however long the strobe stays high. The new setpoint appears after the second clock edge that samples the strobe high.
- R11: Synchronous `rst` puts the block at home in full-step mode, with zero magnitudes, `drive_en_o` low and `at_home_n_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step strobe; each rising edge moves one step |
| dir_i | input | 1 | 1 = increasing angle, 0 = decreasing |
| home_n_i | input | 1 | Active-low return to home; also captures the mode |
| en_i | input | 1 | Output enable |
| mode_i | input | 2 | Resolution code |
| torque_i | input | 2 | Torque scaling code |
| a_mag_o | output | 7 | Winding A magnitude in percent |
| a_neg_o | output | 1 | Winding A setpoint is negative |
| b_mag_o | output | 7 | Winding B magnitude in percent |
| b_neg_o | output | 1 | Winding B setpoint is negative |
| drive_en_o | output | 1 | Outputs are driven |
| at_home_n_o | output | 1 | Low while at the home position |

## Verification
The assertions assume that `mode_i` is only meant to change while `home_n_i` is low. They also assume that `step_i` is held for at least one clock in each level, so that every strobe edge is seen. The stimulus always sets the mode inside a home interval. Only the directed mode-capture test moves it with home released, and that test checks that the change is ignored. Every strobe is driven high and low for at least two clock periods each. All inputs change on the falling clock edge, so they are stable at the sampling edge.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int POS_W   = 6;
  localparam int QIDX_W  = 4;
  localparam int MAG_W   = 7;
  localparam int PCT_W   = 7;
  localparam logic [POS_W-1:0] HOME_POS = POS_W'(8);
  localparam logic [MAG_W-1:0] FULL_MAG = MAG_W'(100);

  typedef enum logic [1:0] {
    MODE_FULL   = 2'b00,
    MODE_HALF   = 2'b01,
    MODE_FINE16 = 2'b10,
    MODE_FINE8  = 2'b11
  } step_mode_e;

  // Quarter-wave magnitude at fine slot 0..16 (0 deg .. 90 deg)
  function automatic logic [MAG_W-1:0] quarter_sine(input logic [QIDX_W:0] idx);
    case (idx)
      5'd0:  quarter_sine = MAG_W'(0);
      5'd1:  quarter_sine = MAG_W'(10);
      5'd2:  quarter_sine = MAG_W'(20);
      5'd3:  quarter_sine = MAG_W'(29);
      5'd4:  quarter_sine = MAG_W'(38);
      5'd5:  quarter_sine = MAG_W'(47);
      5'd6:  quarter_sine = MAG_W'(56);
      5'd7:  quarter_sine = MAG_W'(63);
      5'd8:  quarter_sine = MAG_W'(71);
      5'd9:  quarter_sine = MAG_W'(77);
      5'd10: quarter_sine = MAG_W'(83);
      5'd11: quarter_sine = MAG_W'(88);
      5'd12: quarter_sine = MAG_W'(92);
      5'd13: quarter_sine = MAG_W'(96);
      5'd14: quarter_sine = MAG_W'(98);
      default: quarter_sine = MAG_W'(100);
    endcase
  endfunction

  // Fine slots skipped per step in each resolution
  function automatic logic [POS_W-1:0] step_inc(input step_mode_e m);
    case (m)
      MODE_FULL:   step_inc = POS_W'(16);
      MODE_HALF:   step_inc = POS_W'(8);
      MODE_FINE8:  step_inc = POS_W'(2);
      default:     step_inc = POS_W'(1);
    endcase
  endfunction

  function automatic logic [PCT_W-1:0] torque_pct(input logic [1:0] code);
    case (code)
      2'b00:   torque_pct = PCT_W'(100);
      2'b01:   torque_pct = PCT_W'(75);
      2'b10:   torque_pct = PCT_W'(50);
      default: torque_pct = PCT_W'(20);
    endcase
  endfunction
endpackage

// File: rtl/seq_pos_counter.sv
module seq_pos_counter
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             home_n_i,
  input  logic [1:0]       mode_i,
  output logic [POS_W-1:0] pos_o,
  output step_mode_e       mode_o
);
  logic             step_q;
  logic             step_rise;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] inc;
  step_mode_e       mode_q;

  assign step_rise = step_i & ~step_q;
  assign inc       = step_inc(mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= 1'b0;
      pos_q  <= HOME_POS;
      mode_q <= MODE_FULL;
    end else begin
      step_q <= step_i;
      if (!home_n_i) begin
        pos_q  <= HOME_POS;
        mode_q <= step_mode_e'(mode_i);
      end else if (step_rise) begin
        pos_q <= dir_i ? pos_q + inc : pos_q - inc;
      end
    end
  end

  assign pos_o  = pos_q;
  assign mode_o = mode_q;

  assert_home_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !home_n_i |=> (pos_q == HOME_POS));

  assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    home_n_i |=> $stable(mode_q));

  assert_no_move_without_edge_R10: assert property (@(posedge clk) disable iff (rst)
    (home_n_i && !step_rise) |=> $stable(pos_q));

  assert_full_step_grid_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_FULL) |-> (pos_q[QIDX_W-1:0] == HOME_POS[QIDX_W-1:0]));
endmodule

// File: rtl/seq_amp_lookup.sv
module seq_amp_lookup
  import seq_pkg::*;
(
  input  logic [POS_W-1:0] pos_i,
  input  step_mode_e       mode_i,
  output logic [MAG_W-1:0] cos_mag_o,
  output logic             cos_neg_o,
  output logic [MAG_W-1:0] sin_mag_o,
  output logic             sin_neg_o
);
  logic [1:0]        quad;
  logic [QIDX_W:0]   fwd_idx;
  logic [QIDX_W:0]   rev_idx;
  logic [MAG_W-1:0]  fwd_mag;
  logic [MAG_W-1:0]  rev_mag;
  logic [MAG_W-1:0]  cos_raw;
  logic [MAG_W-1:0]  sin_raw;

  always_comb begin
    quad    = pos_i[POS_W-1:POS_W-2];
    fwd_idx = {1'b0, pos_i[QIDX_W-1:0]};
    rev_idx = (QIDX_W+1)'(16) - fwd_idx;
    fwd_mag = quarter_sine(fwd_idx);
    rev_mag = quarter_sine(rev_idx);
    // odd quadrants swap which winding rises
    cos_raw = quad[0] ? fwd_mag : rev_mag;
    sin_raw = quad[0] ? rev_mag : fwd_mag;
    if (mode_i == MODE_FULL) begin
      cos_mag_o = FULL_MAG;
      sin_mag_o = FULL_MAG;
    end else begin
      cos_mag_o = cos_raw;
      sin_mag_o = sin_raw;
    end
    cos_neg_o = (quad[1] ^ quad[0]) && (cos_mag_o != '0);
    sin_neg_o = quad[1] && (sin_mag_o != '0);
  end
endmodule

// File: rtl/seq_torque_scale.sv
module seq_torque_scale
  import seq_pkg::*;
#(
  parameter int W = MAG_W
) (
  input  logic [W-1:0]     mag_i,
  input  logic [PCT_W-1:0] pct_i,
  output logic [W-1:0]     mag_o
);
  localparam int PROD_W = W + PCT_W;
  localparam logic [PROD_W-1:0] DIV = PROD_W'(100);

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod  = PROD_W'(mag_i) * PROD_W'(pct_i);
    mag_o = W'(prod / DIV);
  end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             home_n_i,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       torque_i,
  output logic [MAG_W-1:0] a_mag_o,
  output logic             a_neg_o,
  output logic [MAG_W-1:0] b_mag_o,
  output logic             b_neg_o,
  output logic             drive_en_o,
  output logic             at_home_n_o
);
  localparam int NPH = 2;

  logic [POS_W-1:0] pos;
  step_mode_e       mode_cur;
  logic [MAG_W-1:0] raw_mag [NPH];
  logic             raw_neg [NPH];
  logic [MAG_W-1:0] sc_mag  [NPH];
  logic [PCT_W-1:0] pct;

  seq_pos_counter u_pos (
    .clk      (clk),
    .rst      (rst),
    .step_i   (step_i),
    .dir_i    (dir_i),
    .home_n_i (home_n_i),
    .mode_i   (mode_i),
    .pos_o    (pos),
    .mode_o   (mode_cur)
  );

  seq_amp_lookup u_lut (
    .pos_i     (pos),
    .mode_i    (mode_cur),
    .cos_mag_o (raw_mag[0]),
    .cos_neg_o (raw_neg[0]),
    .sin_mag_o (raw_mag[1]),
    .sin_neg_o (raw_neg[1])
  );

  assign pct = torque_pct(torque_i);

  for (genvar ph = 0; ph < NPH; ph++) begin : g_phase
    seq_torque_scale #(.W(MAG_W)) u_scale (
      .mag_i (raw_mag[ph]),
      .pct_i (pct),
      .mag_o (sc_mag[ph])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_mag_o     <= '0;
      a_neg_o     <= 1'b0;
      b_mag_o     <= '0;
      b_neg_o     <= 1'b0;
      drive_en_o  <= 1'b0;
      at_home_n_o <= 1'b0;
    end else begin
      drive_en_o  <= en_i;
      at_home_n_o <= (pos != HOME_POS);
      a_mag_o     <= en_i ? sc_mag[0] : '0;
      b_mag_o     <= en_i ? sc_mag[1] : '0;
      a_neg_o     <= en_i && raw_neg[0] && (sc_mag[0] != '0);
      b_neg_o     <= en_i && raw_neg[1] && (sc_mag[1] != '0);
    end
  end

  assert_off_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!drive_en_o && a_mag_o == '0 && b_mag_o == '0 && !a_neg_o && !b_neg_o));

  assert_mag_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (a_mag_o <= FULL_MAG) && (b_mag_o <= FULL_MAG));

  assert_sign_needs_mag_R9: assert property (@(posedge clk) disable iff (rst)
    (!a_neg_o || a_mag_o != '0) && (!b_neg_o || b_mag_o != '0));
endmodule

// File: tb/stepper_phase_seq_tb.sv
module stepper_phase_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_i = 1'b0;
  logic       dir_i = 1'b1;
  logic       home_n_i = 1'b1;
  logic       en_i = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic [1:0] torque_i = 2'b00;
  logic [6:0] a_mag_o, b_mag_o;
  logic       a_neg_o, b_neg_o, drive_en_o, at_home_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stepper_phase_seq dut_i (
    .clk(clk), .rst(rst), .step_i(step_i), .dir_i(dir_i), .home_n_i(home_n_i),
    .en_i(en_i), .mode_i(mode_i), .torque_i(torque_i),
    .a_mag_o(a_mag_o), .a_neg_o(a_neg_o), .b_mag_o(b_mag_o), .b_neg_o(b_neg_o),
    .drive_en_o(drive_en_o), .at_home_n_o(at_home_n_o)
  );

  typedef struct packed {
    logic [1:0]        mode;
    logic              dir;
    logic [7:0]        steps;
    logic [1:0]        tq;
    logic signed [7:0] exp_a;
    logic signed [7:0] exp_b;
    logic              mon;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b1, 8'd1,  2'b00, -8'sd100,  8'sd100, 1'b1},
    '{2'b00, 1'b1, 8'd2,  2'b00, -8'sd100, -8'sd100, 1'b1},
    '{2'b00, 1'b0, 8'd1,  2'b00,  8'sd100, -8'sd100, 1'b1},
    '{2'b00, 1'b1, 8'd4,  2'b00,  8'sd100,  8'sd100, 1'b0},
    '{2'b01, 1'b1, 8'd1,  2'b00,  8'sd0,    8'sd100, 1'b1},
    '{2'b01, 1'b1, 8'd3,  2'b00, -8'sd100,  8'sd0,   1'b1},
    '{2'b01, 1'b0, 8'd1,  2'b00,  8'sd100,  8'sd0,   1'b1},
    '{2'b01, 1'b0, 8'd3,  2'b00,  8'sd0,   -8'sd100, 1'b1},
    '{2'b11, 1'b1, 8'd1,  2'b00,  8'sd56,   8'sd83,  1'b1},
    '{2'b11, 1'b1, 8'd3,  2'b00,  8'sd20,   8'sd98,  1'b1},
    '{2'b11, 1'b0, 8'd4,  2'b00,  8'sd100,  8'sd0,   1'b1},
    '{2'b11, 1'b1, 8'd5,  2'b00, -8'sd20,   8'sd98,  1'b1},
    '{2'b10, 1'b1, 8'd1,  2'b00,  8'sd63,   8'sd77,  1'b1},
    '{2'b10, 1'b1, 8'd7,  2'b00,  8'sd10,   8'sd100, 1'b1},
    '{2'b10, 1'b0, 8'd9,  2'b00,  8'sd100, -8'sd10,  1'b1},
    '{2'b10, 1'b1, 8'd64, 2'b00,  8'sd71,   8'sd71,  1'b0},
    '{2'b11, 1'b1, 8'd32, 2'b00,  8'sd71,   8'sd71,  1'b0},
    '{2'b10, 1'b1, 8'd1,  2'b01,  8'sd47,   8'sd57,  1'b1},
    '{2'b11, 1'b1, 8'd1,  2'b11,  8'sd11,   8'sd16,  1'b1},
    '{2'b00, 1'b1, 8'd0,  2'b10,  8'sd50,   8'sd50,  1'b0}
  };

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_set(string tag, logic signed [7:0] ea, logic signed [7:0] eb);
    logic [6:0] ma, mb;
    ma = 7'(ea < 0 ? -ea : ea);
    mb = 7'(eb < 0 ? -eb : eb);
    checks++;
    if (a_mag_o !== ma || a_neg_o !== (ea < 0) || b_mag_o !== mb || b_neg_o !== (eb < 0)) begin
      errors++;
      $display("FAIL %s: got A=%s%0d B=%s%0d expected A=%0d B=%0d", tag,
               a_neg_o ? "-" : "+", a_mag_o, b_neg_o ? "-" : "+", b_mag_o, ea, eb);
    end
  endtask

  task automatic go_home(logic [1:0] m);
    @(negedge clk); home_n_i = 1'b0; mode_i = m;
    @(negedge clk); @(negedge clk);
    home_n_i = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic pulse_step(logic d);
    @(negedge clk); dir_i = d; step_i = 1'b1;
    @(negedge clk);
    @(negedge clk); step_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check_set("R11 reset setpoints", 8'sd0, 8'sd0);
    check_bit("R11 reset drive_en", drive_en_o, 1'b0);
    check_bit("R11 reset monitor", at_home_n_o, 1'b0);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    check_set("R11 home full-step after reset", 8'sd100, 8'sd100);

    // Vector walk: R1 R2 R3 R4 R8 R9
    for (int v = 0; v < NV; v++) begin
      torque_i = VECS[v].tq;
      go_home(VECS[v].mode);
      for (int s = 0; s < int'(VECS[v].steps); s++) pulse_step(VECS[v].dir);
      @(negedge clk);
      check_set($sformatf("R1 R2 R4 R8 R9 vector %0d", v), VECS[v].exp_a, VECS[v].exp_b);
      check_bit($sformatf("R3 monitor vector %0d", v), at_home_n_o, VECS[v].mon);
    end
    torque_i = 2'b00;

    // R10 latency and single move per edge
    go_home(2'b01);
    check_set("R3 half home", 8'sd71, 8'sd71);
    @(negedge clk); dir_i = 1'b1; step_i = 1'b1;
    @(negedge clk);
    check_set("R10 one edge after strobe", 8'sd71, 8'sd71);
    @(negedge clk);
    check_set("R10 two edges after strobe", 8'sd0, 8'sd100);
    repeat (6) @(negedge clk);
    check_set("R10 held strobe moves once", 8'sd0, 8'sd100);
    step_i = 1'b0;
    @(negedge clk);

    // R5 gating, position keeps counting
    go_home(2'b01);
    en_i = 1'b0;
    pulse_step(1'b1);
    check_set("R5 outputs off", 8'sd0, 8'sd0);
    check_bit("R5 drive_en low", drive_en_o, 1'b0);
    en_i = 1'b1;
    @(negedge clk); @(negedge clk);
    check_set("R5 position advanced while gated", 8'sd0, 8'sd100);
    check_bit("R5 drive_en back", drive_en_o, 1'b1);

    // R6 strobes ignored during home
    @(negedge clk); home_n_i = 1'b0;
    pulse_step(1'b1);
    pulse_step(1'b1);
    check_set("R6 held at home", 8'sd71, 8'sd71);
    check_bit("R6 monitor low", at_home_n_o, 1'b0);
    home_n_i = 1'b1;
    @(negedge clk); @(negedge clk);

    // R7 mode change outside home ignored
    mode_i = 2'b10;
    pulse_step(1'b1);
    @(negedge clk);
    check_set("R7 mode change ignored", 8'sd0, 8'sd100);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule